// File: doc/BRIEF.md
# MAC control and status register file

This block is the software-visible configuration and status space of an Ethernet MAC. A host reaches it through a simple request port: valid, write enable, byte offset and 32-bit data. Every access receives a response one cycle later. The block stores the mode, interrupt, inter-packet gap, frame-length, collision, descriptor-count, control, MII management, station-address and hash registers. It drives their fields straight to the transmit and receive DMA engines and to the filter logic.

A fixed byte range of the offset space is forwarded to the descriptor RAM as a word-indexed port. The RAM's synchronous read data returns on the response cycle. The interrupt-source register merges hardware event pulses with software write-one-to-clear acknowledgement. The interrupt line is the masked OR of its bits. Two writes have side effects beyond storage. Setting the soft-reset bit in the mode register returns the whole block to its reset state and tells both engines to do the same. Writing the descriptor count re-seats the receive descriptor index.

Top module: `mac_csr`

## Requirements
- R1: After reset, register reads return: 0x00 → 0x0000A000, 0x0C → 0x12, 0x10 → 0x0C, 0x14 → 0x12, 0x18 → 0x003C0600, 0x1C → 0x000F003F, 0x20 → 0x40, 0x28 → 0x64, and 0 for every other register. `min_len_o` is 0x3C (bits 31:16 of 0x18) and `max_len_o` is 0x600 (bits 15:0 of 0x18).
- R2: A write to the interrupt source at 0x04 clears each bit written as 1 and leaves the bits written as 0 unchanged.
- R3: A set pulse on `irq_set_i[k]` sets source bit k on the next edge. When that pulse coincides with a software clear of the same bit, the bit ends up set.
- R4: `irq_o` is high exactly when some interrupt-source bit and the same bit of the interrupt mask at 0x08 are both 1.
- R5: A write to 0x00 with bit 11 set restores every register, including interrupt source and mask, to its R1 value. It also pulses `soft_rst_o` for one cycle. Bit 11 is never stored and reads back 0.
- R6: A write to 0x20 stores only wdata bits 7:0. From the next cycle `rx_idx_o` equals twice the stored value, and `rx_idx_load_o` pulses for one cycle. A soft reset also pulses it, with `rx_idx_o` = 0x80.
- R7: 0x3C holds station bytes 3, 2, 1, 0 from bits 31:24 down to 7:0. 0x40 holds byte 5 in bits 15:8 and byte 4 in bits 7:0. `mac_addr_o[8k+7:8k]` carries byte k.
- R8: An access whose offset is not a multiple of 4 responds with `err_o` = 1 and read data 0. It changes no register and issues no descriptor RAM request.
- R9: Offsets 0x400 to 0x7FC access descriptor RAM word (offset − 0x400)/4. Writes forward the data. Reads return `bd_rdata_i` as sampled on the response cycle.
- R10: Aligned offsets from 0x4C to 0x3FC are unmapped. Reads return 0 with `err_o` = 1, and writes there change nothing.
- R11: Writable bits per register; other bits read 0:
  - 0x00: 0x0001F7FF
  - 0x04 and 0x08: bits 6:0
  - 0x0C, 0x10, 0x14: 0x7F
  - 0x18: all
  - 0x1C: 0x000F003F
  - 0x20: 0xFF
  - 0x24: 0x7
  - 0x28: 0x1FF
  - 0x2C: 0x7
  - 0x30: 0x1F1F
  - 0x34, 0x38: 0xFFFF
  - 0x3C: all
  - 0x40: 0xFFFF
  - 0x44, 0x48: all
- R12: `rsp_valid_o` is high in the cycle after each request, and read data and `err_o` are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW (11) | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, response cycle |
| rsp_valid_o | output | 1 | Response cycle marker |
| err_o | output | 1 | Access rejected |
| bd_req_o | output | 1 | Descriptor RAM request |
| bd_we_o | output | 1 | Descriptor RAM write |
| bd_addr_o | output | log2(BD_WORDS) (8) | Descriptor RAM word index |
| bd_wdata_o | output | 32 | Descriptor RAM write data |
| bd_rdata_i | input | 32 | Descriptor RAM read data, one cycle after request |
| irq_set_i | input | IRQW (7) | Hardware event pulses |
| irq_o | output | 1 | Masked interrupt line |
| mode_o | output | 32 | Mode register |
| min_len_o | output | 16 | Minimum frame length |
| max_len_o | output | 16 | Maximum frame length |
| rx_idx_o | output | 9 | Receive descriptor start index |
| rx_idx_load_o | output | 1 | Pulse: reload receive index |
| soft_rst_o | output | 1 | Pulse: engines return to reset |
| mac_addr_o | output | 48 | Station address, byte k at bits 8k+7:8k |
| hash_o | output | 64 | Hash filter words {0x48, 0x44} |

## Verification
The bench attacks the same-cycle race between a hardware set pulse and a software clear on one source bit. A design that lets the clear win drops an event and shows 0 where 2 is expected. A misaligned access into the descriptor window and to the descriptor-count offset must leave both untouched. A decoder that ignores the low offset bits would write RAM word 0 or reload the receive index. The soft reset is checked on every register, the mask register included. This catches a reset path that misses a register or lets the mode write store bit 11. The station-address byte order is checked at the pins, where a reversed layout shows a swapped 48-bit value.

// File: rtl/mac_csr_pkg.sv
package mac_csr_pkg;
  localparam int NREG      = 19;
  localparam int R_MODE    = 0;
  localparam int R_ISRC    = 1;
  localparam int R_IMSK    = 2;
  localparam int R_PKTLEN  = 6;
  localparam int R_TXBD    = 8;
  localparam int R_MAC0    = 15;
  localparam int R_MAC1    = 16;
  localparam int R_HASH0   = 17;
  localparam int R_HASH1   = 18;
  localparam int SRST_BIT  = 11;

  function automatic logic [31:0] rst_val(int i);
    case (i)
      0:       return 32'h0000_A000;
      3:       return 32'h0000_0012;
      4:       return 32'h0000_000C;
      5:       return 32'h0000_0012;
      6:       return 32'h003C_0600;
      7:       return 32'h000F_003F;
      8:       return 32'h0000_0040;
      10:      return 32'h0000_0064;
      default: return 32'h0;
    endcase
  endfunction

  // interrupt registers live in the irq unit, so they are 0 here
  function automatic logic [31:0] wr_mask(int i);
    case (i)
      0:          return 32'h0001_F7FF;
      3, 4, 5:    return 32'h0000_007F;
      6:          return 32'hFFFF_FFFF;
      7:          return 32'h000F_003F;
      8:          return 32'h0000_00FF;
      9:          return 32'h0000_0007;
      10:         return 32'h0000_01FF;
      11:         return 32'h0000_0007;
      12:         return 32'h0000_1F1F;
      13, 14:     return 32'h0000_FFFF;
      15:         return 32'hFFFF_FFFF;
      16:         return 32'h0000_FFFF;
      17, 18:     return 32'hFFFF_FFFF;
      default:    return 32'h0;
    endcase
  endfunction
endpackage

// File: rtl/mac_csr_decode.sv
module mac_csr_decode
  import mac_csr_pkg::*;
#(
  parameter int AW       = 11,
  parameter int BD_BASE  = 1024,
  parameter int BD_WORDS = 256,
  localparam int BDAW    = $clog2(BD_WORDS),
  localparam int RIW     = $clog2(NREG)
) (
  input  logic [AW-1:0]   addr_i,
  output logic            hit_reg_o,
  output logic [RIW-1:0]  reg_idx_o,
  output logic            hit_bd_o,
  output logic [BDAW-1:0] bd_idx_o
);
  localparam int BD_LAST = BD_BASE + 4 * BD_WORDS - 1;

  logic aligned;
  int   off;

  assign aligned   = (addr_i[1:0] == 2'b00);
  assign off       = int'(addr_i);
  assign hit_reg_o = aligned && ((off >> 2) < NREG);
  assign reg_idx_o = RIW'(off >> 2);
  assign hit_bd_o  = aligned && (off >= BD_BASE) && (off <= BD_LAST);
  assign bd_idx_o  = BDAW'((off - BD_BASE) >> 2);
endmodule

// File: rtl/mac_csr_store.sv
module mac_csr_store
  import mac_csr_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  soft_rst_i,
  input  logic [NREG-1:0]       wr_i,
  input  logic [31:0]           wdata_i,
  output logic [NREG-1:0][31:0] q_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [31:0] RV = rst_val(g);
    localparam logic [31:0] MK = wr_mask(g);
    if (MK == 32'h0) begin : g_const
      logic unused_wr;
      assign unused_wr = wr_i[g];
      assign q_o[g]    = RV;
    end else begin : g_ff
      logic [31:0] r_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        r_q <= RV;
        else if (soft_rst_i) r_q <= RV;
        else if (wr_i[g])   r_q <= wdata_i & MK;
      end
      assign q_o[g] = r_q;
    end
  end
endmodule

// File: rtl/mac_csr_irq.sv
module mac_csr_irq #(
  parameter int IRQW = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            soft_rst_i,
  input  logic            clr_en_i,
  input  logic            msk_en_i,
  input  logic [IRQW-1:0] wbits_i,
  input  logic [IRQW-1:0] irq_set_i,
  output logic [IRQW-1:0] src_o,
  output logic [IRQW-1:0] msk_o,
  output logic            irq_o
);
  logic [IRQW-1:0] src_q, msk_q, clr;

  assign clr = clr_en_i ? wbits_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0;
      msk_q <= '0;
    end else if (soft_rst_i) begin
      src_q <= '0;
      msk_q <= '0;
    end else begin
      src_q <= (src_q & ~clr) | irq_set_i;  // set beats clear
      if (msk_en_i) msk_q <= wbits_i;
    end
  end

  assign src_o = src_q;
  assign msk_o = msk_q;
  assign irq_o = |(src_q & msk_q);

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_set_i != '0 && !soft_rst_i) |=> ((src_q & $past(irq_set_i)) == $past(irq_set_i))); // R3
  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && !soft_rst_i && irq_set_i == '0) |=> ((src_q & $past(wbits_i)) == '0)); // R2
  AST_W1C_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_en_i && !soft_rst_i) |=> ((src_q & $past(src_q)) == $past(src_q))); // R2
endmodule

// File: rtl/mac_csr.sv
module mac_csr
  import mac_csr_pkg::*;
#(
  parameter int AW       = 11,
  parameter int BD_BASE  = 1024,
  parameter int BD_WORDS = 256,
  parameter int IRQW     = 7,
  localparam int BDAW    = $clog2(BD_WORDS),
  localparam int RIW     = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [31:0]     wdata_i,
  output logic [31:0]     rdata_o,
  output logic            rsp_valid_o,
  output logic            err_o,
  output logic            bd_req_o,
  output logic            bd_we_o,
  output logic [BDAW-1:0] bd_addr_o,
  output logic [31:0]     bd_wdata_o,
  input  logic [31:0]     bd_rdata_i,
  input  logic [IRQW-1:0] irq_set_i,
  output logic            irq_o,
  output logic [31:0]     mode_o,
  output logic [15:0]     min_len_o,
  output logic [15:0]     max_len_o,
  output logic [8:0]      rx_idx_o,
  output logic            rx_idx_load_o,
  output logic            soft_rst_o,
  output logic [47:0]     mac_addr_o,
  output logic [63:0]     hash_o
);
  logic                  hit_reg, hit_bd;
  logic [RIW-1:0]        ridx;
  logic [NREG-1:0]       wr;
  logic [NREG-1:0][31:0] q;
  logic [IRQW-1:0]       isrc, imsk;
  logic                  wr_any, soft_rst;
  logic [31:0]           rd_val, rdata_q;
  logic                  sel_bd_q, rsp_q, err_q, srst_q, rxld_q;

  mac_csr_decode #(.AW(AW), .BD_BASE(BD_BASE), .BD_WORDS(BD_WORDS)) u_dec (
    .addr_i    (addr_i),
    .hit_reg_o (hit_reg),
    .reg_idx_o (ridx),
    .hit_bd_o  (hit_bd),
    .bd_idx_o  (bd_addr_o)
  );

  assign wr_any   = req_i && we_i && hit_reg;
  assign soft_rst = wr_any && (ridx == RIW'(R_MODE)) && wdata_i[SRST_BIT];

  for (genvar g = 0; g < NREG; g++) begin : g_wr
    assign wr[g] = wr_any && (ridx == RIW'(g));
  end

  mac_csr_store u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst),
    .wr_i       (wr),
    .wdata_i    (wdata_i),
    .q_o        (q)
  );

  mac_csr_irq #(.IRQW(IRQW)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst),
    .clr_en_i   (wr[R_ISRC]),
    .msk_en_i   (wr[R_IMSK]),
    .wbits_i    (wdata_i[IRQW-1:0]),
    .irq_set_i  (irq_set_i),
    .src_o      (isrc),
    .msk_o      (imsk),
    .irq_o      (irq_o)
  );

  always_comb begin
    rd_val = '0;
    if (hit_reg) begin
      if (ridx == RIW'(R_ISRC))      rd_val = 32'(isrc);
      else if (ridx == RIW'(R_IMSK)) rd_val = 32'(imsk);
      else                           rd_val = q[ridx];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      sel_bd_q <= 1'b0;
      rsp_q    <= 1'b0;
      err_q    <= 1'b0;
      srst_q   <= 1'b0;
      rxld_q   <= 1'b0;
    end else begin
      rdata_q  <= (req_i && !we_i) ? rd_val : '0;
      sel_bd_q <= req_i && !we_i && hit_bd;
      rsp_q    <= req_i;
      err_q    <= req_i && !hit_reg && !hit_bd;
      srst_q   <= soft_rst;
      rxld_q   <= soft_rst || wr[R_TXBD];
    end
  end

  assign rdata_o       = sel_bd_q ? bd_rdata_i : rdata_q;
  assign rsp_valid_o   = rsp_q;
  assign err_o         = err_q;
  assign bd_req_o      = req_i && hit_bd;
  assign bd_we_o       = we_i;
  assign bd_wdata_o    = wdata_i;
  assign soft_rst_o    = srst_q;
  assign rx_idx_load_o = rxld_q;
  assign rx_idx_o      = {q[R_TXBD][7:0], 1'b0};
  assign mode_o        = q[R_MODE];
  assign min_len_o     = q[R_PKTLEN][31:16];
  assign max_len_o     = q[R_PKTLEN][15:0];
  assign mac_addr_o    = {q[R_MAC1][15:0], q[R_MAC0]};
  assign hash_o        = {q[R_HASH1], q[R_HASH0]};

  AST_SOFT_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == '0 && wdata_i[SRST_BIT])
      |=> (mode_o == 32'h0000_A000 && rx_idx_o == 9'h080 && soft_rst_o && !irq_o)); // R5
  AST_RX_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == AW'(4 * R_TXBD))
      |=> (rx_idx_o == {$past(wdata_i[7:0]), 1'b0} && rx_idx_load_o)); // R6
  AST_MISALIGN_NO_RAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i[1:0] != 2'b00) |-> !bd_req_o); // R8
  AST_MISALIGN_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i[1:0] != 2'b00) |=> (err_o && rdata_o == '0)); // R8
  AST_ERR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && err_o) |-> (rdata_o == '0)); // R10
  AST_RSP_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o); // R12
  AST_LOAD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rx_idx_load_o && !soft_rst_o); // R6
endmodule

// File: tb/sim_mac_csr.sv
module sim_mac_csr;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 19;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [10:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rsp_valid, err;
  logic        bd_req, bd_we;
  logic [7:0]  bd_addr;
  logic [31:0] bd_wdata;
  logic [31:0] bd_rdata = '0;
  logic [6:0]  irq_set = '0;
  logic        irq;
  logic [31:0] mode;
  logic [15:0] min_len, max_len;
  logic [8:0]  rx_idx;
  logic        rx_idx_load, soft_rst;
  logic [47:0] mac_addr;
  logic [63:0] hash;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] exp_r [NR];
  logic [31:0] ram [256];
  logic [31:0] exp_bd [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_csr u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rsp_valid_o(rsp_valid), .err_o(err),
    .bd_req_o(bd_req), .bd_we_o(bd_we), .bd_addr_o(bd_addr),
    .bd_wdata_o(bd_wdata), .bd_rdata_i(bd_rdata), .irq_set_i(irq_set),
    .irq_o(irq), .mode_o(mode), .min_len_o(min_len), .max_len_o(max_len),
    .rx_idx_o(rx_idx), .rx_idx_load_o(rx_idx_load), .soft_rst_o(soft_rst),
    .mac_addr_o(mac_addr), .hash_o(hash)
  );

  // descriptor RAM model, synchronous read
  always @(posedge clk) begin
    if (bd_req) begin
      if (bd_we) ram[bd_addr] <= bd_wdata;
      else       bd_rdata     <= ram[bd_addr];
    end
  end

  function automatic logic [31:0] f_rst(int i);
    case (i)
      0: return 32'hA000; 3: return 32'h12; 4: return 32'h0C; 5: return 32'h12;
      6: return 32'h003C0600; 7: return 32'h000F003F; 8: return 32'h40;
      10: return 32'h64; default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] f_mask(int i);
    case (i)
      0: return 32'h0001F7FF; 1, 2: return 32'h7F; 3, 4, 5: return 32'h7F;
      6: return 32'hFFFFFFFF; 7: return 32'h000F003F; 8: return 32'hFF;
      9: return 32'h7; 10: return 32'h1FF; 11: return 32'h7; 12: return 32'h1F1F;
      13, 14: return 32'hFFFF; 15: return 32'hFFFFFFFF; 16: return 32'hFFFF;
      default: return 32'hFFFFFFFF;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [10:0] a, input logic [31:0] d,
                     input logic [6:0] s, output logic [31:0] rd, output logic e);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; irq_set = s;
    @(negedge clk);
    req = 1'b0; we = 1'b0; irq_set = '0;
    rd = rdata; e = err;
    checks++;
    if (rsp_valid !== 1'b1) begin
      errors++;
      $display("FAIL R12 rsp_valid actual=%0b expected=1", rsp_valid);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [31:0] d);
    logic [31:0] rd; logic e;
    acc(1'b1, a, d, '0, rd, e);
  endtask

  task automatic rdc(input string tag, input logic [10:0] a, input logic [31:0] exp);
    logic [31:0] rd; logic e;
    acc(1'b0, a, 32'h0, '0, rd, e);
    chk(tag, rd, exp);
  endtask

  task automatic check_all_reset(input string tag);
    for (int i = 0; i < NR; i++) rdc(tag, 11'(4 * i), f_rst(i));
  endtask

  initial begin
    logic [31:0] rd, d;
    logic e;
    int idx;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) begin ram[i] = '0; exp_bd[i] = '0; end
    for (int i = 0; i < NR; i++) exp_r[i] = f_rst(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check_all_reset("R1 reset");
    chk("R1 min_len", min_len, 64'h3C);
    chk("R1 max_len", max_len, 64'h600);
    chk("R1 mode_o", mode, 64'hA000);
    chk("R6 rx_idx reset", rx_idx, 64'h80);
    chk("R4 irq reset", irq, 0);

    // R11 random write/readback
    for (int n = 0; n < 300; n++) begin
      idx = $urandom_range(0, NR - 1);
      if (idx == 1) idx = 2;
      d = $urandom;
      if (idx == 0) d[11] = 1'b0;
      wr(11'(4 * idx), d);
      exp_r[idx] = d & f_mask(idx);
      rdc("R11 readback", 11'(4 * idx), exp_r[idx]);
      if (idx == 8) chk("R6 rx_idx random", rx_idx, {55'h0, exp_r[8][7:0], 1'b0});
    end
    chk("R11 mode_o", mode, exp_r[0]);
    chk("R11 hash_o", hash, {exp_r[18], exp_r[17]});
    chk("R11 min_len", min_len, exp_r[6][31:16]);
    chk("R11 max_len", max_len, exp_r[6][15:0]);

    // R7 station address layout
    wr(11'h3C, 32'h33221100);
    wr(11'h40, 32'hDEAD5544);
    chk("R7 mac_addr", mac_addr, 64'h554433221100);
    rdc("R7 word1", 11'h40, 32'h5544);

    // R6 descriptor count
    acc(1'b1, 11'h20, 32'h000001A5, '0, rd, e);
    chk("R6 load pulse", rx_idx_load, 1);
    chk("R6 rx_idx", rx_idx, 64'h14A);
    @(negedge clk);
    chk("R6 load one cycle", rx_idx_load, 0);
    rdc("R6 low 8 bits", 11'h20, 32'hA5);

    // R2 / R3 / R4 interrupt
    wr(11'h08, 32'h0);
    wr(11'h04, 32'h7F);
    acc(1'b0, 11'h00, 32'h0, 7'h7F, rd, e);
    rdc("R3 set all", 11'h04, 32'h7F);
    chk("R4 masked off", irq, 0);
    wr(11'h04, 32'h05);
    rdc("R2 w1c", 11'h04, 32'h7A);
    acc(1'b1, 11'h04, 32'h7F, 7'h02, rd, e);
    rdc("R3 set beats clear", 11'h04, 32'h02);
    wr(11'h08, 32'h02);
    chk("R4 irq on", irq, 1);
    wr(11'h08, 32'h7D);
    chk("R4 other mask", irq, 0);
    wr(11'h08, 32'h02);
    wr(11'h04, 32'h02);
    chk("R4 cleared", irq, 0);

    // R8 misaligned
    wr(11'h20, 32'h11);
    acc(1'b1, 11'h21, 32'h77, '0, rd, e);
    chk("R8 err write", e, 1);
    acc(1'b0, 11'h22, 32'h0, '0, rd, e);
    chk("R8 err read", e, 1);
    chk("R8 rdata zero", rd, 0);
    rdc("R8 reg untouched", 11'h20, 32'h11);
    chk("R8 rx_idx untouched", rx_idx, 64'h22);
    wr(11'h400, 32'hCAFE0001); exp_bd[0] = 32'hCAFE0001;
    acc(1'b1, 11'h402, 32'hBAD00BAD, '0, rd, e);
    chk("R8 err window", e, 1);
    rdc("R8 ram untouched", 11'h400, 32'hCAFE0001);

    // R9 descriptor window
    for (int n = 0; n < 60; n++) begin
      idx = $urandom_range(0, 255);
      d = $urandom;
      if (n == 0) idx = 255;
      wr(11'(1024 + 4 * idx), d);
      exp_bd[idx] = d;
    end
    for (int n = 0; n < 256; n += 17) rdc("R9 window read", 11'(1024 + 4 * n), exp_bd[n]);
    rdc("R9 last word", 11'h7FC, exp_bd[255]);
    rdc("R9 first word", 11'h400, exp_bd[0]);

    // R10 unmapped
    acc(1'b1, 11'h3FC, 32'h12345678, '0, rd, e);
    chk("R10 err write", e, 1);
    acc(1'b0, 11'h3FC, 32'h0, '0, rd, e);
    chk("R10 err read", e, 1);
    chk("R10 rdata zero", rd, 0);
    acc(1'b0, 11'h04C, 32'h0, '0, rd, e);
    chk("R10 first unmapped", {rd, 31'h0, e}, {32'h0, 31'h0, 1'b1});
    rdc("R10 ram untouched", 11'h400, exp_bd[0]);

    // R5 soft reset
    wr(11'h44, 32'h1234);
    wr(11'h08, 32'h7F);
    acc(1'b0, 11'h00, 32'h0, 7'h10, rd, e);
    chk("R5 irq before", irq, 1);
    acc(1'b1, 11'h00, 32'h00000803, '0, rd, e);
    chk("R5 soft_rst pulse", soft_rst, 1);
    chk("R5 rx load pulse", rx_idx_load, 1);
    chk("R5 irq cleared", irq, 0);
    @(negedge clk);
    chk("R5 pulse one cycle", soft_rst, 0);
    check_all_reset("R5 all reset");
    chk("R5 rx_idx", rx_idx, 64'h80);
    chk("R5 mac_addr", mac_addr, 0);

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule